// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block schedules a small set of outgoing message buffers for a serial frame transmitter. Software writes a control word into a buffer: a request bit, a two-bit priority and an interrupt enable. Setting the request bit only places the buffer in a queue. When the transmitter reports the bus idle, the scheduler picks the most urgent queued buffer. It pulses a start-of-frame strobe with that buffer's index and holds the index until the transmitter returns a result strobe: success, error or lost arbitration. The scheduler then updates the buffer's flags. Message payload storage and bit timing belong to other blocks.

A failed or out-bid attempt leaves the request standing, so the buffer competes again at the next idle bus. Software can withdraw one buffer by writing its request bit to zero, or withdraw every queued buffer with a one-cycle global abort pulse. A buffer that is waiting in the queue is withdrawn at once. A buffer already on the wire is withdrawn only when its attempt fails. If that attempt succeeds, the abort is dropped and the message counts as sent.

The control logic has two states. In `S_IDLE` nothing is on the wire. It moves to `S_SEND` on the start condition: bus idle, at least one request, and no abort in force. The start-of-frame strobe is driven in that same cycle. `S_SEND` returns to `S_IDLE` on the clock edge at which any result strobe is high.

Top module: `txq_sched`

## Requirements
- R1: After reset every buffer's status reads zero, `tx_busy`, `irq` and `abort_pend` are low, and `sof` is low even with `bus_idle` high.
- R2: In `S_IDLE`, with `bus_idle` high, at least one request set and no abort in force, `sof` is high in the same cycle. `tx_idx` then names the requesting buffer with the largest priority code (3 highest, 0 lowest). Among equal codes the larger index wins.
- R3: A request or priority written on an edge before the start cycle counts in that selection. From start of frame until the result, `tx_idx` holds the chosen buffer even if priorities change.
- R4: Writing a buffer with its request bit set clears that buffer's error, lost-arbitration and abort flags.
- R5: A success result clears the sending buffer's request bit and sets its done flag only if its enable is set. `irq` is the OR of all done flags. Any write to a buffer clears its done flag.
- R6: An error result sets the buffer's error flag. A lost-arbitration result sets its lost-arbitration flag. In both cases the request stays set and the done flag is untouched.
- R7: Writing a zero request to a queued buffer that is not on the wire clears its request and sets its abort flag on that edge. The done flag stays clear.
- R8: A zero-request write to the buffer on the wire keeps its request set until the result. On success the abort is dropped: request clear, abort flag clear, done flag per enable. On error or lost arbitration the request clears and the abort flag sets, alongside the result flag.
- R9: An `abort_all` pulse withdraws every queued buffer not on the wire on that edge and blocks start of frame in that cycle. If a buffer is on the wire, `abort_pend` stays high and that buffer is treated as in R8 at its result. `abort_pend` then falls on the result edge.
- R10: Result strobes outside `S_SEND` have no effect. When several result strobes are high together, success takes precedence over error, and error over lost arbitration.
- R11: Status word layout (`rd_stat`): bits 1:0 priority, bit 2 interrupt enable, bit 3 request, bit 4 error, bit 5 lost arbitration, bit 6 abort, bit 7 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | IW | Buffer index for the write |
| wr_req | input | 1 | Request bit written |
| wr_prio | input | PW | Priority written |
| wr_ie | input | 1 | Interrupt enable written |
| abort_all | input | 1 | One-cycle global abort request |
| rd_sel | input | IW | Buffer index for the status read |
| rd_stat | output | PW+6 | Status word of the selected buffer (R11) |
| abort_pend | output | 1 | Global abort waiting on the buffer on the wire |
| bus_idle | input | 1 | Transmitter reports an idle bus |
| sof | output | 1 | Start-of-frame strobe |
| tx_idx | output | IW | Index of the chosen or sending buffer |
| tx_busy | output | 1 | A frame is on the wire (`S_SEND`) |
| res_ok | input | 1 | Result strobe: sent |
| res_err | input | 1 | Result strobe: error |
| res_larb | input | 1 | Result strobe: lost arbitration |
| irq | output | 1 | OR of all done flags |

## Verification
The risky overlap is an abort and a transmission result landing on the same buffer. The bench provokes this in two ways. It writes a zero request, or pulses the global abort, while that buffer is on the wire. It then strobes success in one case and error or lost arbitration in the others. Each outcome is judged from the status word on the following cycle: a dropped abort on success, and a withdrawn request with the abort flag on failure. A second overlap, a request written just before the start cycle, is covered by a sweep over every priority and request combination, with the winner computed arithmetically in the bench.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } txq_state_e;

    localparam int FLAG_BITS = 6;
endpackage

// File: rtl/txq_pick.sv
module txq_pick #(
    parameter int NBUF = 3,
    parameter int PW   = 2,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBUF-1:0]    req,
    input  logic [NBUF*PW-1:0] prio,
    output logic               any,
    output logic [IW-1:0]      idx
);
    logic [PW-1:0] best;

    // ascending scan with >= : larger index wins ties
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (req[i] && (!any || prio[i*PW +: PW] >= best)) begin
                any  = 1'b1;
                idx  = IW'(i);
                best = prio[i*PW +: PW];
            end
        end
    end

    p_win_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
    import txq_pkg::*;
#(
    parameter int NBUF = 3,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_idle,
    input  logic          any,
    input  logic [IW-1:0] win_idx,
    input  logic          hold,
    input  logic          res_any,
    output logic          sof,
    output logic          busy,
    output logic [IW-1:0] tx_idx
);
    txq_state_e    state_q, state_d;
    logic [IW-1:0] cur_q;
    logic          start_ok;

    assign start_ok = bus_idle & any & ~hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_ok)
                cur_q <= win_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_ok) state_d = S_SEND;
            S_SEND: if (res_any)  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        sof    = 1'b0;
        busy   = 1'b0;
        tx_idx = cur_q;
        unique case (state_q)
            S_IDLE: begin
                sof    = start_ok;
                tx_idx = win_idx;
            end
            S_SEND: busy = 1'b1;
        endcase
    end

    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(tx_idx));
    p_res_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && res_any |=> !busy);
endmodule

// File: rtl/txq_slot.sv
module txq_slot #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          wr_req,
    input  logic [PW-1:0] wr_prio,
    input  logic          wr_ie,
    input  logic          in_flight,
    input  logic          res_here,
    input  logic          res_ok,
    input  logic          res_err,
    input  logic          glob,
    output logic          req_q,
    output logic [PW-1:0] prio_q,
    output logic          ie_q,
    output logic          err_q,
    output logic          larb_q,
    output logic          abt_q,
    output logic          txif_q
);
    logic          kill_q;
    logic          n_req, n_ie, n_err, n_larb, n_abt, n_txif, n_kill;
    logic [PW-1:0] n_prio;

    always_comb begin
        n_req  = req_q;  n_prio = prio_q; n_ie  = ie_q;
        n_err  = err_q;  n_larb = larb_q; n_abt = abt_q;
        n_txif = txif_q; n_kill = kill_q;
        if (wr) begin
            n_prio = wr_prio;
            n_ie   = wr_ie;
            n_txif = 1'b0;
        end
        if (res_here) begin
            if (res_ok) begin
                n_req  = 1'b0;
                n_txif = ie_q;
                n_kill = 1'b0;
            end else begin
                if (res_err) n_err  = 1'b1;
                else         n_larb = 1'b1;
                if (kill_q || glob) begin
                    n_req  = 1'b0;
                    n_abt  = 1'b1;
                    n_kill = 1'b0;
                end
            end
        end else if (glob && req_q && !in_flight) begin
            n_req = 1'b0;
            n_abt = 1'b1;
        end
        if (wr) begin
            if (wr_req) begin
                n_req  = 1'b1;
                n_err  = 1'b0;
                n_larb = 1'b0;
                n_abt  = 1'b0;
                n_kill = 1'b0;
            end else if (in_flight && !res_here) begin
                n_kill = 1'b1;
            end else if (n_req) begin
                n_req = 1'b0;
                n_abt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0; prio_q <= '0; ie_q <= 1'b0; err_q <= 1'b0;
            larb_q <= 1'b0; abt_q <= 1'b0; txif_q <= 1'b0; kill_q <= 1'b0;
        end else begin
            req_q <= n_req; prio_q <= n_prio; ie_q <= n_ie; err_q <= n_err;
            larb_q <= n_larb; abt_q <= n_abt; txif_q <= n_txif; kill_q <= n_kill;
        end
    end

    p_ok_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_here && res_ok && !wr |=> !req_q);
    p_fail_keeps_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_here && !res_ok && !kill_q && !glob && !wr |=> req_q);
    p_fail_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_here && !res_ok && !wr |=> $stable(txif_q));
    p_abort_queued_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !wr_req && req_q && !in_flight && !res_here |=> !req_q && abt_q);
    p_glob_queued_r9: assert property (@(posedge clk) disable iff (!rst_n)
        glob && req_q && !in_flight && !wr |=> abt_q && !req_q);
endmodule

// File: rtl/txq_sched.sv
module txq_sched #(
    parameter int NBUF = 3,
    parameter int PW   = 2,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int SW  = PW + txq_pkg::FLAG_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_sel,
    input  logic          wr_req,
    input  logic [PW-1:0] wr_prio,
    input  logic          wr_ie,
    input  logic          abort_all,
    input  logic [IW-1:0] rd_sel,
    output logic [SW-1:0] rd_stat,
    output logic          abort_pend,
    input  logic          bus_idle,
    output logic          sof,
    output logic [IW-1:0] tx_idx,
    output logic          tx_busy,
    input  logic          res_ok,
    input  logic          res_err,
    input  logic          res_larb,
    output logic          irq
);
    logic [NBUF-1:0]    req_v, ie_v, err_v, larb_v, abt_v, txif_v;
    logic [NBUF*PW-1:0] prio_v;
    logic [SW-1:0]      stat_a [NBUF];
    logic               any, res_any, eff_abort, gabt_q;
    logic [IW-1:0]      win_idx;

    assign res_any   = res_ok | res_err | res_larb;
    assign eff_abort = abort_all | gabt_q;

    txq_pick #(.NBUF(NBUF), .PW(PW)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(req_v), .prio(prio_v),
        .any(any), .idx(win_idx)
    );

    txq_fsm #(.NBUF(NBUF)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .any(any),
        .win_idx(win_idx), .hold(eff_abort), .res_any(res_any),
        .sof(sof), .busy(tx_busy), .tx_idx(tx_idx)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        logic hit;
        assign hit = (tx_idx == IW'(g)) && (sof || tx_busy);
        txq_slot #(.PW(PW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en && wr_sel == IW'(g)), .wr_req(wr_req),
            .wr_prio(wr_prio), .wr_ie(wr_ie),
            .in_flight(hit), .res_here(hit && tx_busy && res_any),
            .res_ok(res_ok), .res_err(res_err), .glob(eff_abort),
            .req_q(req_v[g]), .prio_q(prio_v[g*PW +: PW]), .ie_q(ie_v[g]),
            .err_q(err_v[g]), .larb_q(larb_v[g]), .abt_q(abt_v[g]),
            .txif_q(txif_v[g])
        );
        assign stat_a[g] = {txif_v[g], abt_v[g], larb_v[g], err_v[g],
                            req_v[g], ie_v[g], prio_v[g*PW +: PW]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gabt_q <= 1'b0;
        else        gabt_q <= eff_abort && tx_busy && !res_any;
    end

    always_comb begin
        rd_stat = '0;
        for (int i = 0; i < NBUF; i++)
            if (rd_sel == IW'(i)) rd_stat = stat_a[i];
    end

    assign abort_pend = gabt_q;
    assign irq        = |txif_v;

    p_sof_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> bus_idle && !abort_all && req_v[tx_idx]);
    p_pend_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pend |-> tx_busy);
endmodule

// File: tb/sim_txq_sched.sv
module sim_txq_sched;
    localparam int CLK_P = 10;
    localparam int B_REQ = 3, B_ERR = 4, B_LARB = 5, B_ABT = 6, B_TXIF = 7;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 0, wr_req = 0, wr_ie = 0, abort_all = 0, bus_idle = 0;
    logic [1:0] wr_sel = 0, rd_sel = 0, wr_prio = 0, tx_idx;
    logic [7:0] rd_stat;
    logic       abort_pend, sof, tx_busy, irq;
    logic       res_ok = 0, res_err = 0, res_larb = 0;
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    txq_sched u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_req(wr_req), .wr_prio(wr_prio), .wr_ie(wr_ie),
        .abort_all(abort_all), .rd_sel(rd_sel), .rd_stat(rd_stat),
        .abort_pend(abort_pend), .bus_idle(bus_idle), .sof(sof),
        .tx_idx(tx_idx), .tx_busy(tx_busy), .res_ok(res_ok),
        .res_err(res_err), .res_larb(res_larb), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_bit(string tag, int sel, int b, int exp);
        rd_sel = 2'(sel);
        #1;
        chk(tag, int'(rd_stat[b]), exp);
    endtask

    task automatic wr_buf(int sel, bit rq, int pr, bit ie);
        wr_en = 1; wr_sel = 2'(sel); wr_req = rq; wr_prio = 2'(pr); wr_ie = ie;
        tick();
        wr_en = 0;
    endtask

    task automatic start_tx(int idx, string tag);
        bus_idle = 1;
        #1;
        chk({tag, " sof"}, int'(sof), 1);
        chk({tag, " idx"}, int'(tx_idx), idx);
        tick();
        bus_idle = 0;
        chk({tag, " busy"}, int'(tx_busy), 1);
    endtask

    task automatic result(bit ok, bit er, bit lb);
        res_ok = ok; res_err = er; res_larb = lb;
        tick();
        res_ok = 0; res_err = 0; res_larb = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

    initial begin
        do_reset();
        // R1 / R11: reset state of every status word
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s); #1;
            chk("R1 status", int'(rd_stat), 0);
        end
        bus_idle = 1; #1;
        chk("R1 sof", int'(sof), 0);
        chk("R1 busy", int'(tx_busy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 abort_pend", int'(abort_pend), 0);
        bus_idle = 0;

        // R2: sweep every request mask and priority triple
        for (int m = 0; m < 8; m++) begin
            for (int pc = 0; pc < 64; pc++) begin
                int p [3];
                int best;
                best = -1;
                for (int i = 0; i < 3; i++) begin
                    p[i] = (pc >> (2*i)) & 3;
                    wr_buf(i, m[i], p[i], 0);
                end
                for (int i = 0; i < 3; i++)
                    if (m[i] && (best < 0 || p[i] >= p[best])) best = i;
                bus_idle = 1; #1;
                chk("R2 sweep sof", int'(sof), (m != 0) ? 1 : 0);
                if (m != 0) chk("R2 sweep idx", int'(tx_idx), best);
                bus_idle = 0;
            end
        end

        do_reset();
        // R3: late request counted; index held while busy
        wr_buf(0, 1, 1, 0);
        wr_buf(1, 1, 2, 0);
        wr_buf(2, 1, 3, 1);
        start_tx(2, "R3 late request");
        wr_buf(0, 1, 3, 0);
        chk("R3 idx held", int'(tx_idx), 2);
        // R5: success
        result(1, 0, 0);
        chk_bit("R5 req cleared", 2, B_REQ, 0);
        chk_bit("R5 done set", 2, B_TXIF, 1);
        chk("R5 irq", int'(irq), 1);
        wr_buf(2, 0, 3, 1);
        chk_bit("R5 write clears done", 2, B_TXIF, 0);
        chk_bit("R5 no abort on idle clear", 2, B_ABT, 0);
        chk("R5 irq low", int'(irq), 0);

        // R6: error, then lost arbitration
        start_tx(0, "R6 start");
        result(0, 1, 0);
        chk_bit("R6 err flag", 0, B_ERR, 1);
        chk_bit("R6 req kept", 0, B_REQ, 1);
        chk_bit("R6 no done", 0, B_TXIF, 0);
        start_tx(0, "R6 retry");
        result(0, 0, 1);
        chk_bit("R6 larb flag", 0, B_LARB, 1);
        chk_bit("R6 req kept larb", 0, B_REQ, 1);
        chk("R6 no irq", int'(irq), 0);
        // R4: rewrite clears flags
        wr_buf(0, 1, 3, 0);
        chk_bit("R4 err cleared", 0, B_ERR, 0);
        chk_bit("R4 larb cleared", 0, B_LARB, 0);

        // R7: abort a queued buffer
        wr_buf(1, 0, 2, 0);
        chk_bit("R7 req cleared", 1, B_REQ, 0);
        chk_bit("R7 abort flag", 1, B_ABT, 1);
        chk_bit("R7 no done", 1, B_TXIF, 0);

        // R8: abort in flight, then success -> ignored
        start_tx(0, "R8 start");
        wr_buf(0, 0, 3, 1);
        chk_bit("R8 req held", 0, B_REQ, 1);
        chk_bit("R8 no abort yet", 0, B_ABT, 0);
        result(1, 0, 0);
        chk_bit("R8 ok req", 0, B_REQ, 0);
        chk_bit("R8 ok abort dropped", 0, B_ABT, 0);
        chk_bit("R8 ok done", 0, B_TXIF, 1);
        wr_buf(0, 1, 3, 0);
        chk_bit("R8 rewrite done clear", 0, B_TXIF, 0);
        // R8: abort in flight, then error -> honored
        start_tx(0, "R8 restart");
        wr_buf(0, 0, 3, 0);
        result(0, 1, 0);
        chk_bit("R8 err req", 0, B_REQ, 0);
        chk_bit("R8 err abort", 0, B_ABT, 1);
        chk_bit("R8 err flag", 0, B_ERR, 1);

        // R9: global abort during a transmission
        wr_buf(0, 1, 0, 0);
        wr_buf(1, 1, 1, 0);
        wr_buf(2, 1, 2, 0);
        start_tx(2, "R9 start");
        abort_all = 1;
        tick();
        abort_all = 0;
        chk_bit("R9 buf0 req", 0, B_REQ, 0);
        chk_bit("R9 buf0 abort", 0, B_ABT, 1);
        chk_bit("R9 buf1 abort", 1, B_ABT, 1);
        chk("R9 pend", int'(abort_pend), 1);
        tick();
        chk_bit("R9 flight req held", 2, B_REQ, 1);
        result(0, 0, 1);
        chk_bit("R9 flight req", 2, B_REQ, 0);
        chk_bit("R9 flight abort", 2, B_ABT, 1);
        chk_bit("R9 flight larb", 2, B_LARB, 1);
        chk("R9 pend cleared", int'(abort_pend), 0);
        // R9: global abort while idle blocks start
        wr_buf(1, 1, 3, 0);
        bus_idle = 1; abort_all = 1; #1;
        chk("R9 no sof", int'(sof), 0);
        tick();
        abort_all = 0; bus_idle = 0;
        chk_bit("R9 idle req", 1, B_REQ, 0);
        chk_bit("R9 idle abort", 1, B_ABT, 1);
        chk("R9 idle no pend", int'(abort_pend), 0);

        // R10: strobes while idle ignored; precedence
        wr_buf(2, 1, 1, 1);
        result(1, 1, 1);
        chk_bit("R10 idle req", 2, B_REQ, 1);
        chk_bit("R10 idle err", 2, B_ERR, 0);
        chk_bit("R10 idle done", 2, B_TXIF, 0);
        chk("R10 idle busy", int'(tx_busy), 0);
        start_tx(2, "R10 start");
        result(1, 1, 0);
        chk_bit("R10 ok wins req", 2, B_REQ, 0);
        chk_bit("R10 ok wins err", 2, B_ERR, 0);
        chk_bit("R10 ok wins done", 2, B_TXIF, 1);
        chk("R11 prio field", int'(rd_stat[1:0]), 1);

        done = 1;
        report();
    end
endmodule